// File: doc/BRIEF.md
# Programmable CPU-Cycle Interrupt Timer

This block is a 16-bit down-counter that advances once per CPU clock and raises a level interrupt when it expires. Software loads a 16-bit reload value as two separate byte writes. A control byte write starts or stops the count, and a repeat bit in that byte selects one-shot or free-running operation. Every write and read reaches the block as a one-cycle strobe with a shared byte of write data.

A master disk-I/O enable input comes from a register shared with other functions. While it is low, control writes are ignored, the counter is halted and any pending interrupt is dropped. The pending flag drives the interrupt output, and a status read sees it as bit 0. The same read acknowledges the interrupt.

The counter value and the run state are brought out so that a system can watch the count.

Top module: `cyc_irq_timer`

## Requirements
- R1: A pulse on `wr_lo` stores `wdata` into reload bits [7:0], and a pulse on `wr_hi` stores it into reload bits [15:8]. Both writes take effect whatever the level of `io_en`.
- R2: In the control byte, bit 0 is the repeat flag and bit 1 is the enable flag. The repeat flag is stored on every accepted control write.
- R3: An accepted control write with bit 1 set loads the reload value held before that edge into the counter, and `running` goes high on the same edge.
- R4: While `running` is high and the counter is not zero, the counter drops by one on each clock.
- R5: When `running` is high and the counter is zero, the next edge sets `irq` and reloads the counter. A reload value of N therefore gives an `irq` rise N+1 clocks after the enable write.
- R6: At expiry, `running` clears if the repeat flag is 0 and stays high if it is 1. A repeating timer fires every N+1 clocks.
- R7: A reload value of 0 fires on the clock after enabling. With repeat set, it fires on every clock and the counter stays at 0.
- R8: While `io_en` is low, control writes change neither `running` nor the counter.
- R9: While `io_en` is low, `running` and `irq` are 0 after the next edge. This holds even if the timer is expiring in that cycle.
- R10: A control write with bit 1 clear stops the counter and clears `irq` on the next edge. The counter value is held.
- R11: `irq` is a level that stays high until an acknowledge. A `stat_rd` pulse clears it on the next edge, except when a new expiry occurs in the same cycle, in which case `irq` stays high.
- R12: After reset, the counter, reload value, `running`, the repeat flag and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_lo | input | 1 | Strobe: write reload low byte |
| wr_hi | input | 1 | Strobe: write reload high byte |
| wr_ctl | input | 1 | Strobe: write control byte |
| wdata | input | 8 | Write data byte |
| io_en | input | 1 | Master disk-I/O enable level |
| stat_rd | input | 1 | Strobe: status register read (acknowledge) |
| irq | output | 1 | Timer interrupt level and status bit 0 |
| running | output | 1 | Counter enabled |
| count | output | 16 | Current counter value |

## Verification
The counter is run with a small non-zero reload in one-shot mode, which checks the N+1 expiry spacing and the automatic stop. It is then run with a reload whose two bytes differ, loaded while the master enable is low, which checks that the bytes land in the right halves and that reload writes ignore the enable. Repeat mode with reload 2 and with reload 0 separates a periodic timer from the fire-every-cycle case. In the periodic run a status read placed on an expiry cycle checks that the new expiry wins over the acknowledge. The three acknowledge paths are each applied to a held interrupt or a running counter, and a control write issued while the master enable is low shows that the write is ignored.

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic          wr_ctl,
  input  logic [BW-1:0] wdata,
  input  logic          io_en,
  input  logic          stat_rd,
  output logic          irq,
  output logic          running,
  output logic [2*BW-1:0] count
);
  localparam int CW = 2 * BW;

  logic [CW-1:0] rel_q, cnt_q;
  logic          run_q, rep_q, pend_q;
  logic          fire;

  assign fire    = io_en && !wr_ctl && run_q && (cnt_q == '0);
  assign irq     = pend_q;
  assign running = run_q;
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      rep_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_lo) rel_q[BW-1:0]  <= wdata;
      if (wr_hi) rel_q[CW-1:BW] <= wdata;
      if (!io_en) begin
        run_q  <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        if (wr_ctl) begin
          rep_q <= wdata[0];
          run_q <= wdata[1];
          if (wdata[1]) cnt_q  <= rel_q;
          else          pend_q <= 1'b0;
        end else if (run_q) begin
          if (cnt_q == '0) begin
            cnt_q <= rel_q;
            run_q <= rep_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        if (fire)         pend_q <= 1'b1;
        else if (stat_rd) pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cyc_irq_timer_chk.sv
module cyc_irq_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_ctl,
  input logic [1:0]    ctl_bits,
  input logic          io_en,
  input logic          stat_rd,
  input logic          irq,
  input logic          running,
  input logic [CW-1:0] count,
  input logic [CW-1:0] rel_q,
  input logic          rep_q
);
  logic at_zero;
  assign at_zero = running && io_en && !wr_ctl && (count == '0);

  p_master_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !io_en |=> (!irq && !running));

  p_ctl_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_en && wr_ctl && !ctl_bits[1]) |=> (!irq && !running && $stable(count)));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_en && wr_ctl && ctl_bits[1]) |=> (running && count == $past(rel_q)));

  p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && io_en && !wr_ctl && count != '0) |=> (count == $past(count) - 1'b1));

  p_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    at_zero |=> (irq && count == $past(rel_q)));

  p_oneshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && !rep_q) |=> !running);

  p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && io_en && !wr_ctl && !stat_rd) |=> irq);

  p_ignore_ctl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_en && !running) |=> ($stable(count) && !running));
endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(.CW(2*BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .ctl_bits(wdata[1:0]),
  .io_en(io_en), .stat_rd(stat_rd), .irq(irq), .running(running),
  .count(count), .rel_q(rel_q), .rep_q(rep_q)
);

// File: tb/cyc_irq_timer_tb.sv
module cyc_irq_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_lo = 0, wr_hi = 0, wr_ctl = 0, io_en = 0, stat_rd = 0;
  logic [7:0] wdata = '0;
  logic irq, running;
  logic [15:0] count;
  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { logic irq; logic run; logic [15:0] cnt; string tag; } exp_t;
  exp_t q[$];

  logic [15:0] m_rel = 0, m_cnt = 0;
  logic m_run = 0, m_rep = 0, m_pend = 0;

  always #2 clk = ~clk;

  cyc_irq_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_ctl(wr_ctl),
    .wdata(wdata), .io_en(io_en), .stat_rd(stat_rd),
    .irq(irq), .running(running), .count(count)
  );

  task automatic step(input logic lo, input logic hi, input logic ctl, input logic [7:0] d,
                      input logic en, input logic rd, input string tag);
    logic [15:0] rel_n, cnt_n;
    logic run_n, rep_n, pend_n, fire;
    exp_t e;
    @(negedge clk);
    wr_lo = lo; wr_hi = hi; wr_ctl = ctl; wdata = d; io_en = en; stat_rd = rd;
    rel_n = m_rel; cnt_n = m_cnt; run_n = m_run; rep_n = m_rep; pend_n = m_pend; fire = 0;
    if (lo) rel_n[7:0] = d;
    if (hi) rel_n[15:8] = d;
    if (!en) begin
      run_n = 0; pend_n = 0;
    end else begin
      if (ctl) begin
        rep_n = d[0]; run_n = d[1];
        if (d[1]) cnt_n = m_rel; else pend_n = 0;
      end else if (m_run) begin
        if (m_cnt == 0) begin fire = 1; cnt_n = m_rel; run_n = m_rep; end
        else cnt_n = m_cnt - 1;
      end
      if (fire) pend_n = 1;
      else if (rd) pend_n = 0;
    end
    m_rel = rel_n; m_cnt = cnt_n; m_run = run_n; m_rep = rep_n; m_pend = pend_n;
    e.irq = pend_n; e.run = run_n; e.cnt = cnt_n; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle(input int n, input logic en, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00, en, 0, tag);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (irq !== e.irq || running !== e.run || count !== e.cnt) begin
        failures++;
        $display("FAIL %s: irq/run/count actual %b/%b/%0d expected %b/%b/%0d",
                 e.tag, irq, running, count, e.irq, e.run, e.cnt);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (irq !== 0 || running !== 0 || count !== 0) begin
      failures++;
      $display("FAIL R12: reset irq/run/count actual %b/%b/%0d expected 0/0/0", irq, running, count);
    end
    @(negedge clk); rst_n = 1;
    idle(2, 1, "R12");
    // R1: reload bytes written with master enable low
    step(1, 0, 0, 8'h03, 0, 0, "R1");
    step(0, 1, 0, 8'h00, 0, 0, "R1");
    // R3 load, R4 count, R5 fire, R6 one-shot stop
    step(0, 0, 1, 8'h02, 1, 0, "R3");
    idle(3, 1, "R4");
    step(0, 0, 0, 8'h00, 1, 0, "R5");
    idle(3, 1, "R6");
    // R11: level held, then status read acks
    step(0, 0, 0, 8'h00, 1, 1, "R11");
    idle(1, 1, "R11");
    // R1: high byte lands in upper half
    step(0, 1, 0, 8'h01, 0, 0, "R1");
    step(1, 0, 0, 8'h02, 1, 0, "R1");
    step(0, 0, 1, 8'h02, 1, 0, "R3");
    idle(2, 1, "R4");
    // R10: control write with bit 1 clear stops
    step(0, 0, 1, 8'h00, 1, 0, "R10");
    idle(2, 1, "R10");
    // R2/R6: repeat with reload 2
    step(0, 1, 0, 8'h00, 1, 0, "R1");
    step(0, 0, 1, 8'h03, 1, 0, "R2");
    idle(2, 1, "R6");
    step(0, 0, 0, 8'h00, 1, 0, "R5");
    idle(2, 1, "R6");
    // R11: ack on an expiry cycle keeps irq
    step(0, 0, 0, 8'h00, 1, 1, "R11");
    step(0, 0, 0, 8'h00, 1, 1, "R11");
    idle(4, 1, "R6");
    // R10: stop and ack a pending irq
    step(0, 0, 1, 8'h01, 1, 0, "R10");
    idle(1, 1, "R10");
    // R7: zero reload with repeat fires every cycle
    step(1, 0, 0, 8'h00, 1, 0, "R7");
    step(0, 0, 1, 8'h03, 1, 0, "R7");
    idle(3, 1, "R7");
    step(0, 0, 0, 8'h00, 1, 1, "R7");
    // R9: master disable stops and acks
    step(0, 0, 0, 8'h00, 0, 0, "R9");
    idle(1, 1, "R9");
    // R8: control write ignored while master off
    step(1, 0, 0, 8'h05, 1, 0, "R1");
    step(0, 0, 1, 8'h02, 0, 0, "R8");
    idle(3, 1, "R8");
    // R7: zero-reload one-shot
    step(1, 0, 0, 8'h00, 1, 0, "R7");
    step(0, 0, 1, 8'h02, 1, 0, "R7");
    idle(3, 1, "R7");
    // R9: master off while running mid-count
    step(1, 0, 0, 8'h09, 1, 0, "R1");
    step(0, 0, 1, 8'h03, 1, 0, "R3");
    idle(2, 1, "R4");
    step(0, 0, 0, 8'h00, 0, 0, "R9");
    idle(2, 1, "R9");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule